// File: doc/BRIEF.md
# Binary Ring-LWE Column Multiplier

This block multiplies a public polynomial `a`, whose coefficients are `W` bits wide, by a secret polynomial `s` whose coefficients are single bits. The product is taken in the ring of polynomials modulo `x^N + 1`, with coefficient arithmetic modulo `2^W`. Because each secret coefficient is 0 or 1, every partial product is either the current rotated public polynomial or nothing. The datapath therefore has only adders and no multipliers.

The schedule works column by column. In run cycle `i` the public register bank holds `a·x^i mod (x^N+1)`. If the secret bit for that column is 1, all `N` accumulator lanes add their matching coefficient in the same cycle. At the end of the cycle the bank rotates in place by one negacyclic step: the top coefficient leaves and comes back at position 0 negated. The secret register is rotated circularly in step with it, so its low bit always selects the current column. A run takes exactly `N` cycles and keeps no second copy of either operand.

Operands are written one coefficient at a time through an indexed load port while the block is not busy. A run is launched with a one-cycle start pulse, and the result coefficients are read through a combinational indexed port once `done` is high. A small controller sequences the run through three states:
- `ST_IDLE` after reset.
- `ST_RUN` while the columns are processed.
- `ST_DONE` once the result is ready.

The transitions are: accept-start (`ST_IDLE`→`ST_RUN`), last-column (`ST_RUN`→`ST_DONE`) and restart (`ST_DONE`→`ST_RUN`).

Top module: `rlwe_colmul`

## Requirements
- R1: After reset `busy` and `done` are 0 and every result coefficient read through `rd_idx`/`rd_coef` is 0.
- R2: While `busy` is 0, `ld_pub_en` writes `ld_pub_coef` into public coefficient `ld_idx`, and `ld_sec_en` writes `ld_sec_bit` into secret coefficient `ld_idx`.
- R3: A `start` pulse sampled while `busy` is 0 clears the accumulator and raises `busy` on the next cycle. `busy` then stays high for exactly `N` cycles.
- R4: `done` rises in the cycle right after the last of the `N` busy cycles. It stays high until the next accepted start, and `busy` and `done` are never high together.
- R5: When `done` is high, result coefficient `k` equals `sum over i+j=k of a[i]·s[j]` minus `sum over i+j=k+N of a[i]·s[j]`, modulo `2^W`.
- R6: `start` sampled while `busy` is high is ignored: the run length and the result are unchanged.
- R7: Load strobes sampled while `busy` is high are ignored, and the result of the ongoing run is unchanged.
- R8: While `done` is high and no start arrives, the value read for any index stays fixed.
- R9: Each accepted start begins from a zero accumulator, so a result never depends on earlier runs.
- R10: After a completed run the public bank holds `-a` (since `x^N = -1`) and the secret bank is back in its loaded order. A second run without reloading therefore yields the negation of the previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a multiplication |
| ld_pub_en | input | 1 | Write strobe for a public coefficient |
| ld_sec_en | input | 1 | Write strobe for a secret bit |
| ld_idx | input | $clog2(N) | Coefficient index for both load strobes |
| ld_pub_coef | input | W | Public coefficient value to write |
| ld_sec_bit | input | 1 | Secret coefficient value to write |
| busy | output | 1 | High while the columns are being processed |
| done | output | 1 | High while a finished result is held |
| rd_idx | input | $clog2(N) | Result coefficient index to read |
| rd_coef | output | W | Result coefficient at `rd_idx` (combinational) |

## Verification
The assertions assume that `start` is a clean synchronous level that changes only between clock edges. They also assume that `rd_idx` is held steady across a clock edge whenever result stability is judged, because the read port is combinational. The run-length property further assumes that `N` fits the index counter, i.e. `N` is at least 2. The stimulus drives every input on the falling edge. It deliberately holds `start` and the load strobes active during runs only while more than four columns remain, so that no stray start can land in the `ST_DONE` cycle and be legitimately accepted as a restart.

// File: rtl/rlwe_colmul_pkg.sv
package rlwe_colmul_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } mul_state_t;

endpackage

// File: rtl/rlwe_colmul_ctrl.sv
module rlwe_colmul_ctrl
    import rlwe_colmul_pkg::*;
#(
    parameter int N = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done,
    output logic clr,
    output logic step
);
    localparam int IDXW = $clog2(N);
    localparam logic [IDXW-1:0] LAST = IDXW'(N - 1);

    mul_state_t      st_q, st_d;
    logic [IDXW-1:0] col_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // column counter, only advances inside a run
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              col_q <= '0;
        else if (st_q == ST_RUN) col_q <= col_q + 1'b1;
        else                     col_q <= '0;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start)        st_d = ST_RUN;
            ST_RUN:  if (col_q == LAST) st_d = ST_DONE;
            ST_DONE: if (start)        st_d = ST_RUN;
            default:                   st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        clr  = 1'b0;
        step = 1'b0;
        unique case (st_q)
            ST_IDLE: clr = start;
            ST_RUN: begin
                busy = 1'b1;
                step = 1'b1;
            end
            ST_DONE: begin
                done = 1'b1;
                clr  = start;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rlwe_colmul_opnd.sv
module rlwe_colmul_opnd #(
    parameter int N = 256,
    parameter int W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_pub,
    input  logic                      wr_sec,
    input  logic [$clog2(N)-1:0]      wr_idx,
    input  logic [W-1:0]              wr_coef,
    input  logic                      wr_bit,
    input  logic                      step,
    output logic                      col_bit,
    output logic [N-1:0][W-1:0]       pub
);
    localparam int IDXW = $clog2(N);

    logic [N-1:0][W-1:0] pub_q;
    logic [N-1:0]        sec_q;

    // public bank: negacyclic rotation in place, one step per cycle
    for (genvar j = 0; j < N; j++) begin : g_pub
        if (j == 0) begin : g_wrap
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                 pub_q[j] <= '0;
                else if (step)                              pub_q[j] <= -pub_q[N-1];
                else if (wr_pub && wr_idx == IDXW'(j))      pub_q[j] <= wr_coef;
            end
        end else begin : g_shift
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                 pub_q[j] <= '0;
                else if (step)                              pub_q[j] <= pub_q[j-1];
                else if (wr_pub && wr_idx == IDXW'(j))      pub_q[j] <= wr_coef;
            end
        end
    end

    // secret bits: plain circular rotation, bit 0 selects the current column
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sec_q <= '0;
        else if (step)   sec_q <= {sec_q[0], sec_q[N-1:1]};
        else if (wr_sec) sec_q[wr_idx] <= wr_bit;
    end

    assign col_bit = sec_q[0];
    assign pub     = pub_q;
endmodule

// File: rtl/rlwe_colmul_acc.sv
module rlwe_colmul_acc #(
    parameter int N = 256,
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 add_en,
    input  logic [N-1:0][W-1:0]  addend,
    input  logic [$clog2(N)-1:0] rd_idx,
    output logic [W-1:0]         rd_coef
);
    logic [N-1:0][W-1:0] acc_q;

    for (genvar j = 0; j < N; j++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      acc_q[j] <= '0;
            else if (clr)    acc_q[j] <= '0;
            else if (add_en) acc_q[j] <= acc_q[j] + addend[j];
        end
    end

    assign rd_coef = acc_q[rd_idx];
endmodule

// File: rtl/rlwe_colmul.sv
module rlwe_colmul #(
    parameter int N = 256,
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 ld_pub_en,
    input  logic                 ld_sec_en,
    input  logic [$clog2(N)-1:0] ld_idx,
    input  logic [W-1:0]         ld_pub_coef,
    input  logic                 ld_sec_bit,
    output logic                 busy,
    output logic                 done,
    input  logic [$clog2(N)-1:0] rd_idx,
    output logic [W-1:0]         rd_coef
);
    logic                clr, step, col_bit;
    logic [N-1:0][W-1:0] pub;

    rlwe_colmul_ctrl #(.N(N)) ctrl_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .done  (done),
        .clr   (clr),
        .step  (step)
    );

    // loads are only honoured outside a run
    rlwe_colmul_opnd #(.N(N), .W(W)) opnd_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_pub  (ld_pub_en & ~busy),
        .wr_sec  (ld_sec_en & ~busy),
        .wr_idx  (ld_idx),
        .wr_coef (ld_pub_coef),
        .wr_bit  (ld_sec_bit),
        .step    (step),
        .col_bit (col_bit),
        .pub     (pub)
    );

    rlwe_colmul_acc #(.N(N), .W(W)) acc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .add_en  (step & col_bit),
        .addend  (pub),
        .rd_idx  (rd_idx),
        .rd_coef (rd_coef)
    );
endmodule

// File: rtl/rlwe_colmul_chk.sv
module rlwe_colmul_chk #(
    parameter int N = 256,
    parameter int W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 busy,
    input logic                 done,
    input logic [$clog2(N)-1:0] rd_idx,
    input logic [W-1:0]         rd_coef
);
    localparam int LW = $clog2(N) + 1;

    logic [LW-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    assert_start_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R6: starts during a run must not stretch or shorten it
    assert_run_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == LW'(N)));

    assert_busy_exits_to_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    assert_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_done_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    assert_result_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> ($stable(rd_idx) -> $stable(rd_coef)));
endmodule

bind rlwe_colmul rlwe_colmul_chk #(.N(N), .W(W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .rd_idx  (rd_idx),
    .rd_coef (rd_coef)
);

// File: tb/rlwe_colmul_tb_top.sv
`timescale 1ns/1ps
module rlwe_colmul_tb_top;
    localparam int N    = 256;
    localparam int W    = 8;
    localparam int IDXW = $clog2(N);
    localparam int MASK = (1 << W) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            ld_pub_en = 1'b0;
    logic            ld_sec_en = 1'b0;
    logic [IDXW-1:0] ld_idx = '0;
    logic [W-1:0]    ld_pub_coef = '0;
    logic            ld_sec_bit = 1'b0;
    logic            busy, done;
    logic [IDXW-1:0] rd_idx = '0;
    logic [W-1:0]    rd_coef;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 0;

    int ra[N];
    int rs[N];
    int exp_c[N];
    int seed = 32'h1234_5678;

    // behavioural timing model
    bit m_busy = 0, m_done = 0;
    int m_cnt = 0;

    always #2 clk = ~clk;

    rlwe_colmul #(.N(N), .W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .ld_pub_en(ld_pub_en), .ld_sec_en(ld_sec_en), .ld_idx(ld_idx),
        .ld_pub_coef(ld_pub_coef), .ld_sec_bit(ld_sec_bit),
        .busy(busy), .done(done), .rd_idx(rd_idx), .rd_coef(rd_coef)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int rnd();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 8) & 32'h7fff_ffff;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 0; m_done <= 0; m_cnt <= 0;
        end else if (m_busy) begin
            if (m_cnt == N - 1) begin
                m_busy <= 0; m_done <= 1;
            end
            m_cnt <= m_cnt + 1;
        end else if (start) begin
            m_busy <= 1; m_done <= 0; m_cnt <= 0;
        end
    end

    // per-clock comparison of the handshake (R3, R4, R6)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(busy == m_busy, "R3 busy", busy, m_busy);
            chk(done == m_done, "R4 done", done, m_done);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // schoolbook negacyclic product of ra and rs (R5)
    task automatic compute_ref();
        for (int k = 0; k < N; k++) exp_c[k] = 0;
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                if (rs[j] != 0) begin
                    if (i + j < N) exp_c[i+j]   = (exp_c[i+j] + ra[i]) & MASK;
                    else           exp_c[i+j-N] = (exp_c[i+j-N] - ra[i]) & MASK;
                end
    endtask

    task automatic load_all();
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            ld_pub_en = 1; ld_sec_en = 1; ld_idx = IDXW'(k);
            ld_pub_coef = W'(ra[k]); ld_sec_bit = rs[k][0];
        end
        @(negedge clk);
        ld_pub_en = 0; ld_sec_en = 0;
    endtask

    task automatic run_mul(input bit noise);
        compute_ref();
        @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
        for (int c = 0; c < N + 8 && !done; c++) begin
            if (noise && c < N - 4) begin
                // R6, R7: junk stimulus during the run
                start = c[0]; ld_pub_en = 1; ld_sec_en = 1; ld_idx = IDXW'(c);
                ld_pub_coef = W'(8'hA5 ^ c); ld_sec_bit = ~rs[c][0];
            end else begin
                start = 0; ld_pub_en = 0; ld_sec_en = 0;
            end
            @(negedge clk);
        end
        start = 0; ld_pub_en = 0; ld_sec_en = 0;
        chk(done == 1'b1, "R4 done after run", done, 1);
        // R10: bank ends up holding -a
        for (int k = 0; k < N; k++) ra[k] = (-ra[k]) & MASK;
    endtask

    task automatic check_result(input string req);
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            rd_idx = IDXW'(k);
            #1;
            chk(int'(rd_coef) == exp_c[k], req, rd_coef, exp_c[k]);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 0, "R1 busy", busy, 0);
        chk(done == 0, "R1 done", done, 0);
        for (int k = 0; k < N; k += 37) begin
            rd_idx = IDXW'(k); #1;
            chk(rd_coef == 0, "R1 result zero", rd_coef, 0);
        end

        // R2/R5: secret = 1, product equals a
        for (int k = 0; k < N; k++) begin ra[k] = rnd() & MASK; rs[k] = (k == 0); end
        load_all(); run_mul(0); check_result("R2 R5 s=1");

        // R5: secret = x^(N-1), wrap with negation
        for (int k = 0; k < N; k++) begin ra[k] = rnd() & MASK; rs[k] = (k == N - 1); end
        load_all(); run_mul(0); check_result("R5 s=x^(N-1)");

        // R5: all-ones secret
        for (int k = 0; k < N; k++) begin ra[k] = rnd() & MASK; rs[k] = 1; end
        load_all(); run_mul(0); check_result("R5 s all ones");

        // R9: zero secret after a nonzero result gives zero
        for (int k = 0; k < N; k++) begin ra[k] = rnd() & MASK; rs[k] = 0; end
        load_all(); run_mul(0); check_result("R9 cleared accumulator");

        // R6/R7: random operands with junk starts and loads during the run
        for (int k = 0; k < N; k++) begin ra[k] = rnd() & MASK; rs[k] = rnd() & 1; end
        load_all(); run_mul(1); check_result("R6 R7 ignored while busy");

        // R8: result held while idle in done
        repeat (10) @(negedge clk);
        chk(done == 1'b1, "R8 done held", done, 1);
        check_result("R8 result held");

        // R10: rerun without reloading yields the negated product
        run_mul(0); check_result("R10 rerun negated");

        // R5: random case with max coefficients
        for (int k = 0; k < N; k++) begin ra[k] = MASK; rs[k] = rnd() & 1; end
        load_all(); run_mul(0); check_result("R5 max coefficients");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule